// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave for a Two-Wire Serial Bus

This block is an SMBus/I2C target that gives a host access to a small bank of byte-wide configuration registers. The bank is held inside the block, and its contents are brought out flat to the rest of the device. Every write opens with a starting register index and a byte count, and the data bytes follow. A read sets the index with a short write, then issues a repeated start with the read address. The block answers with the stored readback count and then streams the registers from that index onward. The host ends a read with a not-acknowledge and a stop.

SCL and SDA pass through two-flop synchronizers and are oversampled on the system clock. START and STOP are recognised from SDA edges while SCL is high. SDA is open-drain: the block only ever pulls the line low through an enable. Two locations hold fixed identification values. One location holds the readback count and can be written. Out-of-range indexes, surplus bytes and protected locations are acknowledged and then ignored.

Top module: `smb_blk_slave`

## Requirements
- R1: Only the 7-bit address 0x69 is acknowledged (0xD2 for a write, 0xD3 for a read). Any other address gets no acknowledge, and the rest of that transfer drives nothing and changes nothing.
- R2: A write is address, index N, count X, then data. Data byte k (k < X) lands in register N+k, and every byte is acknowledged.
- R3: A read is the index write, a repeated start, then address 0xD3. The block first sends the content of register 8 (the readback count), then the bytes of registers N, N+1 and so on, most significant bit first.
- R4: After reset, register 6 reads 0x13 and register 7 reads 0x21 (revision 2 in the upper nibble, vendor code 0001 in the lower nibble). Register 8 reads 9, and every other register, including register 21, reads 0x00.
- R5: Registers 6 and 7 cannot be written. A data byte aimed at them is acknowledged, the index still advances, and the stored value stays.
- R6: Indexes 22 and above hold no register. Writes there are acknowledged and dropped, and reads there return 0x00.
- R7: Data bytes beyond the write count X are acknowledged and dropped.
- R8: Once a read has delivered as many data bytes as register 8 held when the read began, further bytes read as 0xFF (SDA left released).
- R9: After the host's not-acknowledge, the block releases SDA and drives nothing until the next START.
- R10: A STOP or START in the middle of a byte abandons the transfer without changing any register. A START begins a fresh address phase.
- R11: The index persists between transfers and advances by one after each accepted data byte, so a read that skips the index write continues where the last transfer left off.
- R12: The block starts pulling SDA low only while SCL is low, and never changes SDA during an SCL high phase of a data or acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When 1 the pad pulls SDA low |
| regFlat | output | 176 | Register bank, register i at bits 8i+7..8i |

## Verification
The bench aims at the edges of the register window. One case writes across the protected identification pair. Others write past index 21, send more bytes than the count allows, and read more bytes than register 8 announces. A design that got any of these wrong would overwrite identification data, alias high indexes onto low registers, or keep streaming stale data where 0xFF is due. It also cuts transfers off mid-byte with both STOP and START. A design that commits bytes before they are complete would leave a partly shifted value in a register, and the register image compared on every clock would show it at once. A not-acknowledge followed by further clocking checks that SDA stays released, which catches a slave that keeps shifting out data.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  localparam int IDX_DEVID  = 6;
  localparam int IDX_VENDOR = 7;
  localparam int IDX_BCOUNT = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_IDX, S_CNT, S_WDATA, S_RDATA
  } smbState_t;

  typedef struct packed {
    logic setIdx;   // index byte complete
    logic setCnt;   // count byte complete
    logic wrByte;   // data byte complete
    logic startRd;  // read begins, latch readback count
    logic advRd;    // host acked, fetch next byte
  } smbStb_t;
endpackage

// File: rtl/smb_blk_sync.sv
module smb_blk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclSync  = sclPipe[STAGES-1];
  assign sdaSync  = sdaPipe[STAGES-1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
endmodule

// File: rtl/smb_blk_ctrl.sv
module smb_blk_ctrl import smb_blk_pkg::*; #(
  parameter logic [6:0] SLV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaSync,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] cntByte,
  input  logic [7:0] dataByte,
  output smbStb_t    stb,
  output logic [7:0] rxByte,
  output logic       sdaOe
);
  localparam logic [3:0] LAST_BIT  = 4'd7;
  localparam logic [3:0] ACK_OPEN  = 4'd8;
  localparam logic [3:0] ACK_CLOSE = 4'd9;

  smbState_t  state;
  logic [3:0] bitCnt;
  logic [6:0] rxShift, txShift;
  logic       ackPend, rnw;
  logic       byteDone, slotEnd, addrHit;

  assign rxByte   = {rxShift, sdaSync};
  assign byteDone = (state != S_IDLE) && sclRise && (bitCnt == LAST_BIT);
  assign slotEnd  = sclFall && (bitCnt == ACK_CLOSE);
  assign addrHit  = (rxByte[7:1] == SLV_ADDR);

  always_comb begin
    stb         = '0;
    stb.setIdx  = byteDone && (state == S_IDX);
    stb.setCnt  = byteDone && (state == S_CNT);
    stb.wrByte  = byteDone && (state == S_WDATA);
    stb.startRd = slotEnd && (state == S_ADDR) && rnw;
    stb.advRd   = slotEnd && (state == S_RDATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      ackPend <= 1'b0;
      rnw     <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (startDet) begin
      state   <= S_ADDR;
      bitCnt  <= '0;
      ackPend <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (stopDet) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      ackPend <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (state != S_IDLE) begin
      if (sclRise) begin
        if (bitCnt < ACK_OPEN) begin
          rxShift <= rxByte[6:0];
          bitCnt  <= bitCnt + 4'd1;
        end else if (bitCnt == ACK_OPEN) begin
          bitCnt <= ACK_CLOSE;
          if (state == S_RDATA && sdaSync) state <= S_IDLE;
        end
        if (byteDone) begin
          case (state)
            S_ADDR: begin
              if (addrHit) begin
                ackPend <= 1'b1;
                rnw     <= rxByte[0];
              end else begin
                state <= S_IDLE;
              end
            end
            S_RDATA: ackPend <= 1'b0;
            default: ackPend <= 1'b1;
          endcase
        end
      end
      if (sclFall) begin
        if (bitCnt == ACK_OPEN) begin
          sdaOe <= ackPend;
        end else if (bitCnt == ACK_CLOSE) begin
          bitCnt  <= '0;
          ackPend <= 1'b0;
          case (state)
            S_ADDR: begin
              state   <= rnw ? S_RDATA : S_IDX;
              txShift <= cntByte[6:0];
              sdaOe   <= rnw & ~cntByte[7];
            end
            S_IDX: begin state <= S_CNT;   sdaOe <= 1'b0; end
            S_CNT: begin state <= S_WDATA; sdaOe <= 1'b0; end
            S_RDATA: begin
              txShift <= dataByte[6:0];
              sdaOe   <= ~dataByte[7];
            end
            default: sdaOe <= 1'b0;
          endcase
        end else if (bitCnt != 4'd0 && state == S_RDATA) begin
          sdaOe   <= ~txShift[6];
          txShift <= {txShift[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/smb_blk_regs.sv
module smb_blk_regs import smb_blk_pkg::*; #(
  parameter int         NREG     = 22,
  parameter logic [7:0] DEV_ID   = 8'h13,
  parameter logic [3:0] REV_ID   = 4'h2,
  parameter logic [7:0] BCNT_RST = 8'd9
) (
  input  logic            clk,
  input  logic            rstN,
  input  smbStb_t         stb,
  input  logic [7:0]      rxByte,
  output logic [7:0]      cntByte,
  output logic [7:0]      dataByte,
  output logic [NREG*8-1:0] regFlat
);
  localparam logic [7:0] REG_END = 8'(NREG);

  logic [7:0] idx, wrLeft, rdLeft, dataRaw;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == IDX_DEVID) begin : g_dev
      assign regFlat[8*g+:8] = DEV_ID;
    end else if (g == IDX_VENDOR) begin : g_ven
      assign regFlat[8*g+:8] = {REV_ID, 4'b0001};
    end else begin : g_rw
      localparam logic [7:0] RST_VAL = (g == IDX_BCOUNT) ? BCNT_RST : 8'h00;
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RST_VAL;
        else if (stb.wrByte && wrLeft != 8'd0 && idx == 8'(g)) q <= rxByte;
      end
      assign regFlat[8*g+:8] = q;
    end
  end

  always_comb begin
    dataRaw = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (idx == 8'(i)) dataRaw = regFlat[8*i+:8];
  end

  assign cntByte  = regFlat[8*IDX_BCOUNT+:8];
  assign dataByte = (rdLeft == 8'd0) ? 8'hFF : ((idx < REG_END) ? dataRaw : 8'h00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      wrLeft <= '0;
      rdLeft <= '0;
    end else begin
      if (stb.setIdx) idx <= rxByte;
      if (stb.setCnt) wrLeft <= rxByte;
      if (stb.wrByte && wrLeft != 8'd0) begin
        idx    <= idx + 8'd1;
        wrLeft <= wrLeft - 8'd1;
      end
      if (stb.startRd) rdLeft <= cntByte;
      if (stb.advRd && rdLeft != 8'd0) begin
        idx    <= idx + 8'd1;
        rdLeft <= rdLeft - 8'd1;
      end
    end
  end
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave import smb_blk_pkg::*; #(
  parameter int         NREG     = 22,
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter logic [7:0] DEV_ID   = 8'h13,
  parameter logic [3:0] REV_ID   = 4'h2,
  parameter logic [7:0] BCNT_RST = 8'd9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [NREG*8-1:0] regFlat
);
  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte, cntByte, dataByte;
  smbStb_t stb;

  smb_blk_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  smb_blk_ctrl #(.SLV_ADDR(SLV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaSync(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .cntByte(cntByte), .dataByte(dataByte),
    .stb(stb), .rxByte(rxByte), .sdaOe(sdaOe)
  );

  smb_blk_regs #(.NREG(NREG), .DEV_ID(DEV_ID), .REV_ID(REV_ID), .BCNT_RST(BCNT_RST)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte),
    .cntByte(cntByte), .dataByte(dataByte), .regFlat(regFlat)
  );
endmodule

// File: rtl/smb_blk_chk.sv
module smb_blk_chk import smb_blk_pkg::*; (
  input logic        clk,
  input logic        rstN,
  input logic        sclSync,
  input logic        startDet,
  input logic        stopDet,
  input logic        sdaOe,
  input smbStb_t     stb,
  input logic [15:0] idBytes
);
  // R12: a new pull-down begins only from a low SCL sample
  p_pull_on_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclSync));

  // R10: bus conditions release the line
  p_release_on_cond_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet) |=> !sdaOe);

  // R5: identification bytes never move
  p_id_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    $stable(idBytes));

  // R2: at most one control strobe per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R2: a data byte commits only on a high SCL sample
  p_commit_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByte |-> sclSync);
endmodule

bind smb_blk_slave smb_blk_chk u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .startDet(startDet), .stopDet(stopDet),
  .sdaOe(sdaOe), .stb(stb), .idBytes(regFlat[8*smb_blk_pkg::IDX_VENDOR+7:8*smb_blk_pkg::IDX_DEVID])
);

// File: tb/smb_blk_slave_test.sv
module smb_blk_slave_test;
  localparam int NREG = 22;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic [NREG*8-1:0] regFlat;
  logic [NREG*8-1:0] expVec;

  int  model [NREG];
  int  mIdx = 0;
  bit  steady = 0;
  bit  done = 0;
  int  nChk = 0;
  int  nBad = 0;

  assign sdaLine = sdaM & ~sdaOe;

  smb_blk_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regFlat(regFlat)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference register image, compared on every clock while settled (R2 R5 R6 R7 R10)
  always @(posedge clk) begin
    #1;
    if (rstN && steady && !done) begin
      for (int i = 0; i < NREG; i++) expVec[8*i+:8] = 8'(model[i]);
      nChk++;
      if (regFlat !== expVec) begin
        nBad++;
        $display("FAIL R2/R5/R6/R7/R10 register image act=%h exp=%h", regFlat, expVec);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    scl = 1'b1;  tick(Q);
    sdaM = 1'b0; tick(Q);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    scl = 1'b1;  tick(Q);
    sdaM = 1'b1; tick(2*Q);
  endtask

  task automatic clkBit(input bit b, output bit seen);
    bit oeA;
    sdaM = b; tick(Q);
    scl = 1'b1; tick(1);
    oeA = sdaOe; tick(Q-1);
    seen = sdaLine; tick(Q);
    check(oeA == sdaOe, "R12 SDA steady while SCL high", int'(sdaOe), int'(oeA));
    scl = 1'b0; tick(Q);
  endtask

  task automatic putByte(input int v, output bit acked);
    bit s;
    steady = 0;
    for (int i = 7; i >= 0; i--) clkBit(v[i], s);
    clkBit(1'b1, s);
    acked = !s;
  endtask

  task automatic getByte(input bit ackIt, output int v);
    bit s;
    v = 0;
    for (int i = 0; i < 8; i++) begin
      clkBit(1'b1, s);
      v = (v << 1) | int'(s);
    end
    clkBit(!ackIt, s);
  endtask

  function automatic bit writable(input int i);
    return (i < NREG) && (i != 6) && (i != 7);
  endfunction

  task automatic wrTxn(input int idx, input int cnt, input int data[$]);
    bit a;
    busStart();
    putByte('hD2, a); steady = 1; check(a, "R1 write address ack", int'(a), 1);
    putByte(idx, a);  steady = 1; check(a, "R2 index ack", int'(a), 1);
    mIdx = idx;
    putByte(cnt, a);  steady = 1; check(a, "R2 count ack", int'(a), 1);
    foreach (data[k]) begin
      putByte(data[k], a);
      if (k < cnt) begin
        if (writable(mIdx)) model[mIdx] = data[k];
        mIdx = (mIdx + 1) % 256;
      end
      steady = 1;
      check(a, "R2 R5 R6 R7 data ack", int'(a), 1);
    end
    busStop();
  endtask

  task automatic rdTxn(input int idx, input int n, input string tag);
    bit a;
    int v, left, expv;
    busStart();
    putByte('hD2, a); steady = 1;
    putByte(idx, a);  steady = 1; mIdx = idx;
    busStart();
    putByte('hD3, a); steady = 1; check(a, "R1 read address ack", int'(a), 1);
    getByte(n > 0, v);
    check(v == model[8], "R3 readback count", v, model[8]);
    left = model[8];
    for (int k = 0; k < n; k++) begin
      getByte(k < n - 1, v);
      if (left == 0) expv = 'hFF;
      else expv = (mIdx < NREG) ? model[mIdx] : 0;
      if (left != 0) begin left--; mIdx = (mIdx + 1) % 256; end
      check(v == expv, tag, v, expv);
    end
    busStop();
  endtask

  initial begin
    int v;
    bit a, s;
    for (int i = 0; i < NREG; i++) model[i] = 0;
    model[6] = 'h13; model[7] = 'h21; model[8] = 9;
    tick(5);
    rstN = 1'b1;
    tick(5);
    steady = 1;

    // R4 reset state
    check(regFlat[63:48] == 16'h2113, "R4 identification bytes", int'(regFlat[63:48]), 'h2113);
    check(regFlat[71:64] == 8'd9, "R4 readback count reset", int'(regFlat[71:64]), 9);
    check(regFlat[175:168] == 8'h00, "R4 test register reset", int'(regFlat[175:168]), 0);
    check(sdaOe == 1'b0, "R4 line released at reset", int'(sdaOe), 0);

    // R1 foreign address: no ack, nothing written
    busStart();
    putByte('hA0, a); steady = 1; check(!a, "R1 foreign address nack", int'(a), 0);
    putByte('h00, a); steady = 1; check(!a, "R1 foreign transfer ignored", int'(a), 0);
    putByte('h77, a); steady = 1; check(!a, "R1 foreign data ignored", int'(a), 0);
    busStop();

    // R2 / R3 basic write then read
    wrTxn(0, 3, '{'h11, 'h22, 'h33});
    rdTxn(0, 3, "R3 data from index");

    // R5 write across protected ids, also reprograms count to 4
    wrTxn(5, 4, '{'h55, 'hAA, 'h77, 'h04});
    rdTxn(5, 3, "R5 protected bytes keep value");

    // R8 read past the count
    rdTxn(0, 6, "R8 bytes beyond count");

    // R7 extra write bytes dropped
    wrTxn(10, 2, '{'h01, 'h02, 'h03, 'h04});
    rdTxn(10, 4, "R7 surplus write bytes dropped");

    // R6 writes and reads past the bank
    wrTxn(20, 3, '{'h9A, 'hBC, 'hDE});
    wrTxn(200, 1, '{'h05});
    rdTxn(20, 3, "R6 out-of-range read");

    // R9 not-acknowledge releases the line
    busStart();
    putByte('hD2, a); steady = 1;
    putByte(0, a);    steady = 1;
    busStart();
    putByte('hD3, a); steady = 1;
    getByte(1'b1, v);
    getByte(1'b0, v);
    check(v == model[0], "R9 last byte before nack", v, model[0]);
    tick(Q);
    check(sdaOe == 1'b0, "R9 released after nack", int'(sdaOe), 0);
    for (int i = 0; i < 9; i++) begin
      clkBit(1'b1, s);
      check(s == 1'b1, "R9 silent after nack", int'(s), 1);
    end
    busStop();

    // R10 stop in the middle of a data byte
    busStart();
    putByte('hD2, a); steady = 1;
    putByte(1, a);    steady = 1;
    putByte(2, a);    steady = 1;
    for (int i = 0; i < 4; i++) clkBit(1'b1, s);
    busStop();
    check(regFlat[15:8] == 8'(model[1]), "R10 stop abort keeps register", int'(regFlat[15:8]), model[1]);
    check(sdaOe == 1'b0, "R10 idle after abort", int'(sdaOe), 0);

    // R10 start in the middle of an index byte
    busStart();
    putByte('hD2, a); steady = 1;
    for (int i = 0; i < 3; i++) clkBit(1'b0, s);
    busStart();
    putByte('hD2, a); steady = 1; check(a, "R10 fresh address after start", int'(a), 1);
    putByte(15, a);   steady = 1;
    putByte(1, a);    steady = 1;
    putByte('h5A, a); model[15] = 'h5A; steady = 1;
    busStop();
    check(regFlat[127:120] == 8'h5A, "R10 transfer after restart", int'(regFlat[127:120]), 'h5A);
    check(regFlat[23:16] == 8'(model[2]), "R10 start abort keeps register", int'(regFlat[23:16]), model[2]);

    // R11 index persists and keeps advancing across transfers
    wrTxn(3, 2, '{'h3C, 'h4D});
    busStart();
    putByte('hD2, a); steady = 1;
    putByte(3, a);    steady = 1;
    busStop();
    busStart();
    putByte('hD3, a); steady = 1; check(a, "R11 read without index ack", int'(a), 1);
    getByte(1'b1, v);
    getByte(1'b0, v);
    check(v == 'h3C, "R11 read at stored index", v, 'h3C);
    busStop();
    busStart();
    putByte('hD3, a); steady = 1;
    getByte(1'b1, v);
    getByte(1'b0, v);
    check(v == 'h4D, "R11 index advanced across transfers", v, 'h4D);
    busStop();

    done = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++;
      nBad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule